// File: doc/BRIEF.md
# Masked Glitch-Filtered GPIO Interrupt Controller

This block watches a bank of general-purpose input lines and tells a host processor when one of them has changed level. The host no longer needs to poll the inputs. Each line first passes through its own glitch filter. The filter ignores any new level that does not stay constant for a set number of system-clock cycles. At the default 250 MHz clock, 250 cycles gives a rejection window of about 1 µs. When a filtered level settles on a new value and that line's enable bit is set, a pending flag is latched. The interrupt output is then driven. It is a pull-low request: 1 means "pull the shared open-drain interrupt wire low", and 0 means "release it".

The host writes an enable mask with one bit per line, where bit n gates line n. The mask resets to all zeros. The host learns which lines fired by reading a status word. The read strobe clears the flags, but an event that qualifies in the same cycle as the read survives it. The inputs must already be synchronous to `clk`. Any synchronizer sits outside this block.

Each line's filter is a two-state machine. The states are `FS_STABLE` (the filtered level equals the raw input) and `FS_QUALIFY` (the raw input differs, and a run counter is counting). The filter moves from `FS_STABLE` to `FS_QUALIFY` on the first sample that differs from the filtered level. It returns from `FS_QUALIFY` to `FS_STABLE` in one of two ways. It aborts if the raw input reverts. It commits, updating the level and emitting a one-cycle event, on the FILT_CYCLES-th consecutive differing sample. The output machine has the states `IS_QUIET` (line released) and `IS_ALERT` (line pulled low). It enters `IS_ALERT` whenever the next-cycle pending flags ANDed with the next-cycle mask are non-zero, and returns to `IS_QUIET` otherwise.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, `mask_q` reads 00h, `stat_q` reads 00h and `irq_pull_low` is 0. The filtered levels start at 0.
- R2: A cycle with `mask_we` high loads `mask_wdata` into the mask, which `mask_q` shows after that clock edge. Bit n of the mask enables line n.
- R3: A new level on a line that lasts fewer than FILT_CYCLES consecutive sampled cycles sets no flag and raises no interrupt.
- R4: A new level held for FILT_CYCLES consecutive samples on an enabled line sets bit n of `stat_q` at the edge of the FILT_CYCLES-th sample. `irq_pull_low` is 1 after that same edge, and not after the edge before it.
- R5: Both rising and falling filtered transitions count as events.
- R6: A qualified change on a line whose enable bit is 0 sets no flag. Enabling that line later does not raise an interrupt for the earlier change.
- R7: While `stat_rd` is high, `stat_q` shows the current flags. At that edge all flags clear, and `irq_pull_low` returns to 0 when no new event arrives.
- R8: An event that qualifies on the same edge as a status read stays set after the read and keeps `irq_pull_low` at 1.
- R9: Clearing an enable bit drops that line's contribution to `irq_pull_low` at the writing edge, while its flag stays visible in `stat_q`. Setting the bit again re-asserts `irq_pull_low`.
- R10: `irq_pull_low` is a register output. After each edge it equals the OR over lines of (pending flag AND enable bit).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | NUM_LINES | Raw input levels, synchronous to clk |
| mask_we | input | 1 | Enable-mask write strobe |
| mask_wdata | input | NUM_LINES | New enable mask |
| mask_q | output | NUM_LINES | Current enable mask |
| stat_rd | input | 1 | Status read strobe, clears flags |
| stat_q | output | NUM_LINES | Pending change flags |
| irq_pull_low | output | 1 | 1 = pull the open-drain interrupt wire low |

## Verification
The bench aims at the filter boundary. A pulse one sample shorter than the window must vanish, while one of exactly FILT_CYCLES samples must fire on that exact edge. A counter that is off by one either leaks glitches or delays the interrupt by a cycle. It also lines up a qualifying event with the read strobe. A design that lets the clear win would lose that event for good. It toggles enable bits on lines that are already pending. A design that gated flags at capture time only, or that left the request registered from the old mask, would leave the wire pulled low after masking or would fail to re-assert it. A long seeded random phase then compares every output against a cycle-level model built from the requirements.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic {
        FS_STABLE  = 1'b0,
        FS_QUALIFY = 1'b1
    } filt_state_e;

    typedef enum logic {
        IS_QUIET = 1'b0,
        IS_ALERT = 1'b1
    } irq_state_e;

endpackage

// File: rtl/gpio_glitch_filter.sv
module gpio_glitch_filter
    import gpio_irq_pkg::*;
#(
    parameter int FILT_CYCLES = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o,
    output logic evt_o
);

    localparam int CNT_W = $clog2(FILT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_CYCLES - 1);

    filt_state_e      st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             level_q, level_n;
    logic             commit;

    // next-state logic
    always_comb begin
        st_n    = st_q;
        cnt_n   = cnt_q;
        level_n = level_q;
        commit  = 1'b0;
        unique case (st_q)
            FS_STABLE: begin
                if (raw_i != level_q) begin
                    st_n  = FS_QUALIFY;
                    cnt_n = CNT_W'(1);
                end
            end
            FS_QUALIFY: begin
                if (raw_i == level_q) begin
                    st_n  = FS_STABLE;
                    cnt_n = '0;
                end else if (cnt_q == LAST) begin
                    st_n    = FS_STABLE;
                    cnt_n   = '0;
                    level_n = raw_i;
                    commit  = 1'b1;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            default: begin
                st_n  = FS_STABLE;
                cnt_n = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= FS_STABLE;
            cnt_q   <= '0;
            level_q <= 1'b0;
        end else begin
            st_q    <= st_n;
            cnt_q   <= cnt_n;
            level_q <= level_n;
        end
    end

    // outputs
    always_comb begin
        level_o = level_q;
        evt_o   = commit;
    end

    AST_LEVEL_ONLY_AFTER_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != $past(level_q)) |-> $past(st_q == FS_QUALIFY && cnt_q == LAST))
        else $error("filtered level moved without a full qualifying run"); // R3

endmodule

// File: rtl/gpio_irq_core.sv
module gpio_irq_core
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] evt_i,
    input  logic                 mask_we,
    input  logic [NUM_LINES-1:0] mask_wdata,
    input  logic                 stat_rd,
    output logic [NUM_LINES-1:0] mask_o,
    output logic [NUM_LINES-1:0] stat_o,
    output logic                 irq_o
);

    irq_state_e           st_q, st_n;
    logic [NUM_LINES-1:0] mask_q, mask_n;
    logic [NUM_LINES-1:0] pend_q, pend_n;

    // next-state logic: flags captured only through the current mask
    always_comb begin
        pend_n = (stat_rd ? '0 : pend_q) | (evt_i & mask_q);
        mask_n = mask_we ? mask_wdata : mask_q;
        unique case (st_q)
            IS_QUIET: st_n = (|(pend_n & mask_n)) ? IS_ALERT : IS_QUIET;
            IS_ALERT: st_n = (|(pend_n & mask_n)) ? IS_ALERT : IS_QUIET;
            default:  st_n = IS_QUIET;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= IS_QUIET;
            mask_q <= '0;
            pend_q <= '0;
        end else begin
            st_q   <= st_n;
            mask_q <= mask_n;
            pend_q <= pend_n;
        end
    end

    // outputs
    always_comb begin
        irq_o  = (st_q == IS_ALERT);
        mask_o = mask_q;
        stat_o = pend_q;
    end

    AST_READ_CLEARS_OLD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> ((pend_q & ~$past(evt_i)) == '0))
        else $error("status read left stale flags"); // R7

    AST_NO_FLAG_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(mask_q)) == '0))
        else $error("flag set on a disabled line"); // R6

    AST_MASK_ALL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && mask_wdata == '0) |=> !irq_o)
        else $error("interrupt held after full mask clear"); // R9

    AST_EVENT_SURVIVES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && |(evt_i & mask_q)) |=> (pend_q != '0))
        else $error("event lost at a status read"); // R8

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES   = 8,
    parameter int FILT_CYCLES = 250
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic                 mask_we,
    input  logic [NUM_LINES-1:0] mask_wdata,
    output logic [NUM_LINES-1:0] mask_q,
    input  logic                 stat_rd,
    output logic [NUM_LINES-1:0] stat_q,
    output logic                 irq_pull_low
);

    logic [NUM_LINES-1:0] level_w;
    logic [NUM_LINES-1:0] evt_w;

    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
        gpio_glitch_filter #(
            .FILT_CYCLES(FILT_CYCLES)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (line_in[gi]),
            .level_o(level_w[gi]),
            .evt_o  (evt_w[gi])
        );
    end

    gpio_irq_core #(
        .NUM_LINES(NUM_LINES)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_w),
        .mask_we   (mask_we),
        .mask_wdata(mask_wdata),
        .stat_rd   (stat_rd),
        .mask_o    (mask_q),
        .stat_o    (stat_q),
        .irq_o     (irq_pull_low)
    );

    // a committed event always flips that line's filtered level
    AST_EVENT_FLIPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_w != '0) |=> ((level_w ^ $past(level_w)) == $past(evt_w)))
        else $error("event without matching level change"); // R5

endmodule

// File: tb/sim_gpio_irq_unit.sv
`timescale 1ns/1ps
module sim_gpio_irq_unit;

    localparam int N = 8;
    localparam int F = 250;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] line_in = '0;
    logic         mask_we = 1'b0;
    logic [N-1:0] mask_wdata = '0;
    logic         stat_rd = 1'b0;
    logic [N-1:0] mask_q, stat_q;
    logic         irq_pull_low;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_unit #(.NUM_LINES(N), .FILT_CYCLES(F)) u0 (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_q(mask_q),
        .stat_rd(stat_rd), .stat_q(stat_q), .irq_pull_low(irq_pull_low)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic any_hit(input logic [N-1:0] p, input logic [N-1:0] m);
        return |(p & m);
    endfunction

    // reference model from the requirements
    logic [N-1:0] m_lvl, m_mask, m_pend;
    logic         m_irq;
    int           m_run [N];

    always @(posedge clk) begin
        logic [N-1:0] ev;
        if (!rst_n) begin
            m_lvl = '0; m_mask = '0; m_pend = '0; m_irq = 1'b0;
            for (int k = 0; k < N; k++) m_run[k] = 0;
        end else begin
            ev = '0;
            for (int k = 0; k < N; k++) begin
                if (line_in[k] != m_lvl[k]) begin
                    m_run[k]++;
                    if (m_run[k] == F) begin
                        m_lvl[k] = line_in[k];
                        m_run[k] = 0;
                        ev[k] = 1'b1;
                    end
                end else begin
                    m_run[k] = 0;
                end
            end
            m_pend = (stat_rd ? '0 : m_pend) | (ev & m_mask);
            if (mask_we) m_mask = mask_wdata;
            m_irq = any_hit(m_pend, m_mask);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R10 model irq", {31'd0, irq_pull_low}, {31'd0, m_irq});
            chk("R7 model status", {24'd0, stat_q}, {24'd0, m_pend});
            chk("R2 model mask", {24'd0, mask_q}, {24'd0, m_mask});
        end
    end

    task automatic wmask(input logic [N-1:0] v);
        mask_we = 1'b1; mask_wdata = v;
        tick(1);
        mask_we = 1'b0;
    endtask

    task automatic rd_clear();
        stat_rd = 1'b1;
        tick(1);
        stat_rd = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick(1);
        chk("R1 mask reset", {24'd0, mask_q}, 32'h00);
        chk("R1 status reset", {24'd0, stat_q}, 32'h00);
        chk("R1 irq released", {31'd0, irq_pull_low}, 32'd0);

        wmask(8'h01);
        chk("R2 mask write", {24'd0, mask_q}, 32'h01);

        // R3: pulse one sample short of the window
        line_in[0] = 1'b1; tick(F - 1);
        line_in[0] = 1'b0; tick(F + 2);
        chk("R3 short pulse status", {24'd0, stat_q}, 32'h00);
        chk("R3 short pulse irq", {31'd0, irq_pull_low}, 32'd0);

        // R4: exact boundary
        line_in[0] = 1'b1; tick(F - 1);
        chk("R4 irq one edge early", {31'd0, irq_pull_low}, 32'd0);
        tick(1);
        chk("R4 irq at window", {31'd0, irq_pull_low}, 32'd1);
        chk("R4 status bit0", {24'd0, stat_q}, 32'h01);

        // R7: read shows then clears
        stat_rd = 1'b1;
        chk("R7 status during read", {24'd0, stat_q}, 32'h01);
        tick(1);
        stat_rd = 1'b0;
        chk("R7 status cleared", {24'd0, stat_q}, 32'h00);
        chk("R7 irq released", {31'd0, irq_pull_low}, 32'd0);

        // R5: falling edge counts
        line_in[0] = 1'b0; tick(F);
        chk("R5 falling status", {24'd0, stat_q}, 32'h01);
        chk("R5 falling irq", {31'd0, irq_pull_low}, 32'd1);
        rd_clear();

        // R6: disabled line ignored
        line_in[3] = 1'b1; tick(F + 2);
        chk("R6 disabled status", {24'd0, stat_q}, 32'h00);
        chk("R6 disabled irq", {31'd0, irq_pull_low}, 32'd0);
        wmask(8'h09);
        chk("R6 late enable irq", {31'd0, irq_pull_low}, 32'd0);
        chk("R6 late enable status", {24'd0, stat_q}, 32'h00);

        // R9: masking a pending line
        line_in[0] = 1'b1; tick(F);
        chk("R9 pending irq", {31'd0, irq_pull_low}, 32'd1);
        wmask(8'h08);
        chk("R9 masked irq", {31'd0, irq_pull_low}, 32'd0);
        chk("R9 flag kept", {24'd0, stat_q}, 32'h01);
        wmask(8'h09);
        chk("R9 re-enabled irq", {31'd0, irq_pull_low}, 32'd1);
        rd_clear();

        // R8: event coinciding with a read
        wmask(8'h0B);
        line_in[0] = 1'b0; tick(F);
        chk("R8 line0 pending", {24'd0, stat_q}, 32'h01);
        line_in[1] = 1'b1; tick(F - 1);
        stat_rd = 1'b1;
        tick(1);
        stat_rd = 1'b0;
        chk("R8 event kept", {24'd0, stat_q}, 32'h02);
        chk("R8 irq held", {31'd0, irq_pull_low}, 32'd1);
        rd_clear();

        // seeded random phase, checked by the model
        for (int i = 0; i < 20000; i++) begin
            mask_we    = ($urandom % 100) == 0;
            mask_wdata = N'($urandom);
            stat_rd    = ($urandom % 40) == 0;
            if (($urandom % 150) == 0) line_in[$urandom % N] ^= 1'b1;
            tick(1);
        end
        mask_we = 1'b0; stat_rd = 1'b0;
        tick(2);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule